// File: doc/BRIEF.md
# Clock Phase Error Averaging Estimator

This block measures how far a divided output clock sits from the grid of a nanosecond time counter and turns that measurement into a value for a step correction of the counter. Each input sample is the nanoseconds field of a captured rising edge of the divided clock, offered with a one-cycle valid strobe. The block first removes the fixed capture latency of 35 ns, which is three 8 ns reference periods plus 11 ns. It then reduces the result modulo the 100 ns output period to get a per-sample phase error, and stores that error.

Once 100 samples have been taken, a second pass reads the stored errors back and adds them up. If any sample of the batch lay just below a full period, small errors in the same batch are lifted by one period so that samples on both sides of the zero-error point average correctly. The average is then folded back into range. The block adds two reference periods to the average and presents the result with a one-cycle done pulse. Then it starts a new batch.

Top module: `phase_avg_estimator`

## Requirements
- R1: After reset `corr_valid` is low and `corr_ns` is zero.
- R2: Each accepted sample's error is 100 minus ((timestamp − 35) mod 100), taken modulo 100 so that a timestamp below 35 wraps. The result lies in 1..100, and 100 means zero phase error.
- R3: A batch is flagged high when at least one of its errors lies in 91..99. An error of 90 or of 100 does not set the flag. The flag is cleared before the next batch.
- R4: In a flagged batch, every error below 10 is increased by 100 before it is summed. In a batch that is not flagged, no error is changed.
- R5: A batch holds exactly 100 accepted samples. Its average is the sum of the (possibly lifted) errors divided by 100, with truncation.
- R6: An average above 100 is reduced by 100. An average of exactly 100 is kept.
- R7: `corr_ns` equals 16 plus the folded average.
- R8: `corr_valid` is high for exactly one cycle, in the cycle that follows the 100th clock edge after the edge that accepted the batch's last sample.
- R9: Strobes offered while the summing pass runs, or while `corr_valid` is high, are dropped. The next batch counts only samples accepted after the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_valid | input | 1 | Strobe: a captured edge timestamp is present |
| ts_ns | input | 30 | Nanoseconds field of the captured rising edge |
| corr_valid | output | 1 | One-cycle pulse: a correction is ready |
| corr_ns | output | 7 | Step correction in ns, held until the next result |

## Verification
Sample intake and the summing pass compete for the same cycles. The same is true of sample intake and the done pulse. A strobe arriving while the block is busy must be dropped: it must neither land in the error store nor advance the batch count. The bench provokes this collision by holding `ts_valid` high with random timestamps through the whole summing pass and through the done cycle. It then judges the outcome twice. The correction from the interrupted batch must equal the value computed from the 100 real samples alone. The batch that follows must produce its result exactly 100 edges after its own 100th sample, which a stray counted strobe would shift.

// File: rtl/phase_est_pkg.sv
package phase_est_pkg;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_SUM     = 2'd1,
    ST_DONE    = 2'd2
  } est_state_t;

  // Phase error of one edge: period minus the delay-corrected position inside
  // the period. Reducing modulo the period first keeps it wrap-safe.
  function automatic int unsigned phase_err(int unsigned ts, int unsigned period,
                                            int unsigned delay);
    int unsigned pos;
    int unsigned dly;
    int unsigned adj;
    pos = ts % period;
    dly = delay % period;
    adj = (pos >= dly) ? (pos - dly) : (pos + period - dly);
    return period - adj;
  endfunction

  // True for errors strictly inside the band just below a full period.
  function automatic logic near_top(int unsigned err, int unsigned period,
                                    int unsigned band);
    return (err < period) && (err + band > period);
  endfunction

  // Second-pass lift of small errors when the batch is flagged.
  function automatic int unsigned lift_err(int unsigned err, int unsigned period,
                                           int unsigned band, logic flagged);
    return (flagged && (err < band)) ? (err + period) : err;
  endfunction

  function automatic int unsigned fold_avg(int unsigned avg, int unsigned period);
    return (avg > period) ? (avg - period) : avg;
  endfunction

  function automatic int unsigned form_corr(int unsigned avg, int unsigned ref_ns);
    return 2 * ref_ns + avg;
  endfunction

endpackage

// File: rtl/phase_sample_calc.sv
module phase_sample_calc #(
  parameter int unsigned TS_W      = 30,
  parameter int unsigned ERR_W     = 7,
  parameter int unsigned PERIOD_NS = 100,
  parameter int unsigned DELAY_NS  = 35,
  parameter int unsigned BAND_NS   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [TS_W-1:0]  ts,
  output logic [ERR_W-1:0] err,
  output logic             near
);

  localparam logic [ERR_W-1:0] ERR_MAX = ERR_W'(PERIOD_NS);
  localparam logic [ERR_W-1:0] ERR_MIN = ERR_W'(1);

  int unsigned err_u;

  always_comb begin
    err_u = phase_est_pkg::phase_err(32'(ts), PERIOD_NS, DELAY_NS);
    err   = ERR_W'(err_u);
    near  = phase_est_pkg::near_top(err_u, PERIOD_NS, BAND_NS);
  end

  // R2: every offered error lies in 1..period
  assert_err_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (err >= ERR_MIN) && (err <= ERR_MAX));

endmodule

// File: rtl/phase_err_store.sv
module phase_err_store #(
  parameter int unsigned DEPTH = 100,
  parameter int unsigned ERR_W = 7,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ERR_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [ERR_W-1:0] rdata
);

  logic [ERR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/phase_avg_ctrl.sv
module phase_avg_ctrl #(
  parameter int unsigned SAMPLES   = 100,
  parameter int unsigned PERIOD_NS = 100,
  parameter int unsigned REF_NS    = 8,
  parameter int unsigned BAND_NS   = 10,
  parameter int unsigned ERR_W     = 7,
  parameter int unsigned IDX_W     = 7,
  parameter int unsigned CNT_W     = 7,
  parameter int unsigned SUM_W     = 14,
  parameter int unsigned CORR_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [ERR_W-1:0]  sample_err,
  input  logic              sample_near,
  input  logic [ERR_W-1:0]  rd_err,
  output logic              we,
  output logic [IDX_W-1:0]  waddr,
  output logic [IDX_W-1:0]  raddr,
  output logic              corr_valid,
  output logic [CORR_W-1:0] corr_ns
);

  import phase_est_pkg::*;

  localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(SAMPLES - 1);
  localparam logic [SUM_W-1:0]  SUM_MAX  = SUM_W'(SAMPLES * (PERIOD_NS + BAND_NS - 1));
  localparam logic [CORR_W-1:0] CORR_LO  = CORR_W'(2 * REF_NS);
  localparam logic [CORR_W-1:0] CORR_HI  = CORR_W'(2 * REF_NS + PERIOD_NS);

  est_state_t        state;
  logic [CNT_W-1:0]  wr_cnt;
  logic [CNT_W-1:0]  rd_cnt;
  logic              hi_q;
  logic [SUM_W-1:0]  sum_q;
  logic [CORR_W-1:0] corr_q;

  // named events for the checks
  logic              accept;
  logic              last_wr;
  logic              last_rd;
  logic              busy;

  int unsigned       lifted_u;
  int unsigned       avg_u;
  int unsigned       fold_u;
  logic [SUM_W-1:0]  sum_next;
  logic [CORR_W-1:0] corr_next;

  assign busy    = (state != ST_COLLECT);
  assign accept  = sample_valid && !busy;
  assign last_wr = (wr_cnt == LAST_IDX);
  assign last_rd = (rd_cnt == LAST_IDX);

  assign we    = accept;
  assign waddr = IDX_W'(wr_cnt);
  assign raddr = IDX_W'(rd_cnt);

  always_comb begin
    lifted_u  = lift_err(32'(rd_err), PERIOD_NS, BAND_NS, hi_q);
    sum_next  = sum_q + SUM_W'(lifted_u);
    avg_u     = 32'(sum_next) / SAMPLES;
    fold_u    = fold_avg(avg_u, PERIOD_NS);
    corr_next = CORR_W'(form_corr(fold_u, REF_NS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_COLLECT;
      wr_cnt <= '0;
      rd_cnt <= '0;
      hi_q   <= 1'b0;
      sum_q  <= '0;
      corr_q <= '0;
    end else begin
      unique case (state)
        ST_COLLECT: begin
          if (accept) begin
            wr_cnt <= wr_cnt + 1'b1;
            hi_q   <= hi_q | sample_near;
            if (last_wr) begin
              state  <= ST_SUM;
              rd_cnt <= '0;
              sum_q  <= '0;
            end
          end
        end
        ST_SUM: begin
          sum_q  <= sum_next;
          rd_cnt <= rd_cnt + 1'b1;
          if (last_rd) begin
            corr_q <= corr_next;
            state  <= ST_DONE;
          end
        end
        ST_DONE: begin
          state  <= ST_COLLECT;
          wr_cnt <= '0;
          hi_q   <= 1'b0;
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end

  assign corr_valid = (state == ST_DONE);
  assign corr_ns    = corr_q;

  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |=> !corr_valid);

  // R3: the high flag never carries into the next batch
  assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |=> !hi_q);

  // R9: the sample count holds while the summing pass runs
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUM) |=> $stable(wr_cnt));

  // R5: the running sum stays within the bound of lifted errors
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q <= SUM_MAX);

  // R6/R7: folded correction stays within its window
  assert_corr_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |-> (corr_ns >= CORR_LO) && (corr_ns <= CORR_HI));

endmodule

// File: rtl/phase_avg_estimator.sv
module phase_avg_estimator #(
  parameter int unsigned TS_W      = 30,
  parameter int unsigned PERIOD_NS = 100,
  parameter int unsigned REF_NS    = 8,
  parameter int unsigned PAD_NS    = 11,
  parameter int unsigned BAND_NS   = 10,
  parameter int unsigned SAMPLES   = 100,
  parameter int unsigned CORR_W    = $clog2(2 * REF_NS + PERIOD_NS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ts_valid,
  input  logic [TS_W-1:0]   ts_ns,
  output logic              corr_valid,
  output logic [CORR_W-1:0] corr_ns
);

  localparam int unsigned DELAY_NS = 3 * REF_NS + PAD_NS;
  localparam int unsigned ERR_W    = $clog2(PERIOD_NS + BAND_NS);
  localparam int unsigned CNT_W    = $clog2(SAMPLES + 1);
  localparam int unsigned IDX_W    = $clog2(SAMPLES);
  localparam int unsigned SUM_W    = $clog2(SAMPLES * (PERIOD_NS + BAND_NS) + 1);

  logic [ERR_W-1:0] smp_err;
  logic             smp_near;
  logic [ERR_W-1:0] rd_err;
  logic             st_we;
  logic [IDX_W-1:0] st_waddr;
  logic [IDX_W-1:0] st_raddr;

  phase_sample_calc #(
    .TS_W(TS_W), .ERR_W(ERR_W), .PERIOD_NS(PERIOD_NS),
    .DELAY_NS(DELAY_NS), .BAND_NS(BAND_NS)
  ) u_calc (
    .clk(clk), .rst_n(rst_n), .valid(ts_valid), .ts(ts_ns),
    .err(smp_err), .near(smp_near)
  );

  phase_err_store #(
    .DEPTH(SAMPLES), .ERR_W(ERR_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .we(st_we), .waddr(st_waddr), .wdata(smp_err),
    .raddr(st_raddr), .rdata(rd_err)
  );

  phase_avg_ctrl #(
    .SAMPLES(SAMPLES), .PERIOD_NS(PERIOD_NS), .REF_NS(REF_NS),
    .BAND_NS(BAND_NS), .ERR_W(ERR_W), .IDX_W(IDX_W), .CNT_W(CNT_W),
    .SUM_W(SUM_W), .CORR_W(CORR_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_valid(ts_valid),
    .sample_err(smp_err), .sample_near(smp_near), .rd_err(rd_err),
    .we(st_we), .waddr(st_waddr), .raddr(st_raddr),
    .corr_valid(corr_valid), .corr_ns(corr_ns)
  );

  // R1: no result before a full batch exists after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !corr_valid);

endmodule

// File: tb/phase_avg_estimator_test.sv
module phase_avg_estimator_test;

  localparam int N = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ts_valid = 1'b0;
  logic [29:0] ts_ns = '0;
  logic        corr_valid;
  logic [6:0]  corr_ns;

  int checks = 0;
  int failures = 0;
  int unsigned ts_q [N];

  phase_avg_estimator uut (
    .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .ts_ns(ts_ns),
    .corr_valid(corr_valid), .corr_ns(corr_ns)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // bench view of one error: correct in the full nanosecond range, then reduce
  function automatic int unsigned bench_err(int unsigned ts);
    int unsigned c;
    c = (ts >= 35) ? (ts - 35) : (ts + 1000000000 - 35);
    return 100 - (c % 100);
  endfunction

  function automatic int unsigned ts_for_err(int unsigned e, int unsigned k);
    return (k * 100 + ((100 - e) % 100) + 35) % 1000000000;
  endfunction

  function automatic int unsigned bench_expect();
    bit hv = 0;
    int unsigned total = 0;
    int unsigned a;
    for (int i = 0; i < N; i++) begin
      int unsigned e = bench_err(ts_q[i]);
      if (e >= 91 && e <= 99) hv = 1;
    end
    for (int i = 0; i < N; i++) begin
      int unsigned v = bench_err(ts_q[i]);
      if (hv && v < 10) v = v + 100;
      total += v;
    end
    a = total / 100;
    if (a > 100) a = a - 100;
    return 16 + a;
  endfunction

  task automatic run_batch(input string tags, input bit junk);
    int lat = 0;
    int unsigned exp = bench_expect();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      ts_valid = 1'b1;
      ts_ns = ts_q[i][29:0];
    end
    @(posedge clk);
    @(negedge clk);
    ts_valid = junk;
    ts_ns = 30'($urandom);
    while (lat < 400) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (corr_valid) break;
      ts_ns = 30'($urandom);
    end
    check(lat == N, "R8", "latency", lat, N);
    check(corr_ns == 7'(exp), tags, "correction", corr_ns, exp);
    @(posedge clk);
    @(negedge clk);
    check(!corr_valid, "R8", "pulse width", corr_valid, 0);
    ts_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(corr_valid == 1'b0, "R1", "reset valid", corr_valid, 0);
    check(corr_ns == 7'd0, "R1", "reset corr", corr_ns, 0);
    rst_n = 1'b1;

    // R6: every error 100 -> average exactly 100, kept
    for (int i = 0; i < N; i++) ts_q[i] = ts_for_err(100, $urandom % 9000000);
    run_batch("R6 R7", 1'b1);

    // R3 R4 R6: 99 x 3 plus one 97 -> 102 folded to 2
    for (int i = 0; i < N; i++) ts_q[i] = ts_for_err((i == 40) ? 97 : 3, $urandom % 9000000);
    run_batch("R3 R4 R6", 1'b0);

    // R4: small errors with no flag stay as they are
    for (int i = 0; i < N; i++) ts_q[i] = ts_for_err(5, $urandom % 9000000);
    run_batch("R4 R5", 1'b1);

    // R2: timestamp below the delay wraps
    for (int i = 0; i < N; i++) ts_q[i] = 10;
    run_batch("R2", 1'b0);

    // R3 boundary: 90 does not flag
    for (int i = 0; i < N; i++) ts_q[i] = ts_for_err((i == 7) ? 5 : 90, $urandom % 9000000);
    run_batch("R3 R5", 1'b1);

    // R3 boundary: 91 flags
    for (int i = 0; i < N; i++) ts_q[i] = ts_for_err((i == 7) ? 5 : 91, $urandom % 9000000);
    run_batch("R3 R4", 1'b0);

    // R9: random batches, junk strobes during busy cycles
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < N; i++) ts_q[i] = $urandom % 1000000000;
      run_batch("R2 R5 R9", 1'b1);
    end

    // near-boundary mix of both sides of zero error
    for (int b = 0; b < 3; b++) begin
      for (int i = 0; i < N; i++) begin
        int unsigned e = ($urandom % 2 == 0) ? (95 + $urandom % 6) : (1 + $urandom % 9);
        ts_q[i] = ts_for_err(e, $urandom % 9000000);
      end
      run_batch("R4 R6 R9", 1'b1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule